// File: doc/BRIEF.md
# Single-Wire Bus Master

This block drives one open-drain single-wire serial line that has an external pull-up. A host issues one command at a time through a small strobe interface: a bus reset with a presence check, a byte write, or a byte read. The block then produces the exact low pulses and sample points for every slot. The line is never driven high. The block only asserts an output-enable that pulls the line low, and it watches the line level through a two-stage synchroniser.

All slot timing counts microsecond ticks. A parameterised divider derives these ticks from the system clock. The divider restarts at the beginning of every slot, so each low pulse lasts exactly a whole number of microseconds in clock cycles. A typical identification sequence is a reset, a write of the code 0x33, and then eight byte reads: a family byte, six identifier bytes and a check byte.

Top module: `owm_master`

## Requirements
- R1: After reset, `line_oe` is 0, `busy` is 0, `rd_data` is 0x00 and `presence` is 0.
- R2: A reset command (`cmd` = 2'b00) pulls the line low for exactly 480 µs. It samples the line 70 µs after release and keeps `busy` high for 960 µs plus one clock. One µs is `CLKS_PER_US` clocks.
- R3: After a reset command, `presence` is 1 if the sampled line was low (a device answered) and 0 if it was high.
- R4: A write slot for a 1 bit pulls the line low for exactly 6 µs and then releases it for 64 µs.
- R5: A write slot for a 0 bit pulls the line low for exactly 60 µs and then releases it for 10 µs.
- R6: A write command (`cmd` = 2'b01) sends the 8 bits of `wr_data` with bit 0 first, as 8 back-to-back slots. `busy` stays high for 8 × (70 µs + 1 clock).
- R7: A read slot pulls the line low for exactly 6 µs and samples the line 9 µs after release. The slot takes 70 µs in total, and a read command (`cmd` = 2'b10) keeps `busy` high for 8 × (70 µs + 1 clock).
- R8: In a read command, the first bit received lands in `rd_data` bit 0 and the last in bit 7.
- R9: `busy` is high in the cycle after an accepted `start`. A `start` while `busy` is high is ignored, and `line_oe` is never asserted while `busy` is low.
- R10: `rd_data` changes only when a read command completes, and `presence` changes only when a reset command completes. Both hold their values in between.
- R11: A `start` with `cmd` = 2'b11 is ignored: `busy` stays low, the line stays released, and `rd_data` and `presence` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Command code: 00 bus reset, 01 write byte, 10 read byte, 11 no operation |
| wr_data | input | 8 | Byte to send on a write command |
| start | input | 1 | Starts the command on `cmd` when `busy` is low |
| busy | output | 1 | High while a command runs |
| rd_data | output | 8 | Last byte read |
| presence | output | 1 | 1 when the last reset saw a device answer |
| line_oe | output | 1 | 1 pulls the bus line low; 0 releases it |
| line_in | input | 1 | Level of the bus line |

## Verification
The assertions assume that the host raises `start` only as a single-cycle strobe. They also assume that `line_in` comes from a line that goes low whenever `line_oe` is high, so the synchronised level is meaningful at each sample point. The bench models the device as a second open-drain driver on the same wire. It answers a reset with a presence pulse and drives each read slot low only for a bit value of zero, well inside the sample window. Its start strobes last one cycle, including the one injected mid-command to test that it is ignored.

// File: rtl/owm_pkg.sv
package owm_pkg;
   typedef enum logic [1:0] {
      OWM_CMD_RESET = 2'd0,
      OWM_CMD_WRITE = 2'd1,
      OWM_CMD_READ  = 2'd2,
      OWM_CMD_NOP   = 2'd3
   } owm_cmd_e;

   typedef enum logic [1:0] {
      SLOT_RST = 2'd0,
      SLOT_WR0 = 2'd1,
      SLOT_WR1 = 2'd2,
      SLOT_RD  = 2'd3
   } owm_slot_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_TAIL = 2'd3
   } owm_phase_e;
endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 1) begin : g_bad_div
      $error("owm_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = !clr;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign tick = !clr && (cnt_q == CW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt_q <= '0;
         else if (clr)  cnt_q <= '0;
         else if (tick) cnt_q <= '0;
         else           cnt_q <= cnt_q + 1'b1;
      end

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick); // R2
   end
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("owm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= IDLE_LVL;
         else        chain_q[i] <= (i == 0) ? din : chain_q[(i == 0) ? 0 : i - 1];
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/owm_slot.sv
module owm_slot
   import owm_pkg::*;
#(
   parameter int T_RST_LOW  = 480,
   parameter int T_RST_WAIT = 70,
   parameter int T_RST_TAIL = 410,
   parameter int T_W1_LOW   = 6,
   parameter int T_W1_TAIL  = 64,
   parameter int T_W0_LOW   = 60,
   parameter int T_W0_TAIL  = 10,
   parameter int T_RD_LOW   = 6,
   parameter int T_RD_WAIT  = 9,
   parameter int T_RD_TAIL  = 55
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      go,
   input  owm_slot_e kind,
   input  logic      line_s,
   output logic      oe,
   output logic      tick_clr,
   output logic      done,
   output logic      bit_q
);
   localparam int TMAX_A = (T_RST_LOW > T_RST_TAIL) ? T_RST_LOW : T_RST_TAIL;
   localparam int TMAX_B = (T_W0_LOW > T_W1_TAIL) ? T_W0_LOW : T_W1_TAIL;
   localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
   localparam int CW     = $clog2(TMAX + 1);

   if (T_RST_LOW < 1 || T_RST_WAIT < 1 || T_RST_TAIL < 1 || T_W1_LOW < 1 ||
       T_W1_TAIL < 1 || T_W0_LOW < 1 || T_W0_TAIL < 1 || T_RD_LOW < 1 ||
       T_RD_WAIT < 1 || T_RD_TAIL < 1) begin : g_bad_timing
      $error("owm_slot: every slot interval must be at least 1 us");
   end
   if (T_W1_LOW >= T_W0_LOW) begin : g_bad_order
      $error("owm_slot: a one bit must have a shorter low pulse than a zero bit");
   end

   owm_phase_e    phase_q;
   owm_slot_e     kind_q;
   logic [CW-1:0] cnt_q;
   int            low_len, wait_len, tail_len, lim;
   logic          last;

   always_comb begin
      unique case (kind_q)
         SLOT_RST: begin low_len = T_RST_LOW; wait_len = T_RST_WAIT; tail_len = T_RST_TAIL; end
         SLOT_WR0: begin low_len = T_W0_LOW;  wait_len = 0;          tail_len = T_W0_TAIL;  end
         SLOT_WR1: begin low_len = T_W1_LOW;  wait_len = 0;          tail_len = T_W1_TAIL;  end
         default:  begin low_len = T_RD_LOW;  wait_len = T_RD_WAIT;  tail_len = T_RD_TAIL;  end
      endcase
      unique case (phase_q)
         PH_LOW:  lim = low_len;
         PH_WAIT: lim = wait_len;
         default: lim = tail_len;
      endcase
   end

   assign last     = tick && (cnt_q == CW'(lim - 1));
   assign oe       = (phase_q == PH_LOW);
   assign tick_clr = (phase_q == PH_IDLE);
   assign done     = (phase_q == PH_TAIL) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         kind_q  <= SLOT_RST;
         cnt_q   <= '0;
         bit_q   <= 1'b1;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (go) begin
                  phase_q <= PH_LOW;
                  kind_q  <= kind;
                  cnt_q   <= '0;
               end
            end
            default: begin
               if (last) begin
                  cnt_q <= '0;
                  if (phase_q == PH_LOW) begin
                     phase_q <= (wait_len != 0) ? PH_WAIT : PH_TAIL;
                  end else if (phase_q == PH_WAIT) begin
                     phase_q <= PH_TAIL;
                     bit_q   <= line_s;
                  end else begin
                     phase_q <= PH_IDLE;
                  end
               end else if (tick) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (phase_q == PH_IDLE)); // R9
   AST_SLOT_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> oe); // R7
endmodule

// File: rtl/owm_master.sv
module owm_master
   import owm_pkg::*;
#(
   parameter int CLKS_PER_US = 100,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int T_RST_LOW   = 480,
   parameter int T_RST_WAIT  = 70,
   parameter int T_RST_TAIL  = 410,
   parameter int T_W1_LOW    = 6,
   parameter int T_W1_TAIL   = 64,
   parameter int T_W0_LOW    = 60,
   parameter int T_W0_TAIL   = 10,
   parameter int T_RD_LOW    = 6,
   parameter int T_RD_WAIT   = 9,
   parameter int T_RD_TAIL   = 55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cmd,
   input  logic [DATA_W-1:0] wr_data,
   input  logic             start,
   output logic             busy,
   output logic [DATA_W-1:0] rd_data,
   output logic             presence,
   output logic             line_oe,
   input  logic             line_in
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("owm_master: DATA_W must be at least 1");
   end

   logic              tick, tick_clr, line_s;
   logic              slot_go, slot_done, slot_bit;
   owm_slot_e         slot_kind;
   owm_cmd_e          cur_cmd, req_cmd;
   logic [IDX_W-1:0]  bit_idx;
   logic [DATA_W-1:0] wsh, rsh, rd_q;
   logic              busy_q, pres_q;

   owm_tick #(.DIV(CLKS_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick));

   owm_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_s));

   owm_slot #(
      .T_RST_LOW(T_RST_LOW), .T_RST_WAIT(T_RST_WAIT), .T_RST_TAIL(T_RST_TAIL),
      .T_W1_LOW(T_W1_LOW),   .T_W1_TAIL(T_W1_TAIL),
      .T_W0_LOW(T_W0_LOW),   .T_W0_TAIL(T_W0_TAIL),
      .T_RD_LOW(T_RD_LOW),   .T_RD_WAIT(T_RD_WAIT), .T_RD_TAIL(T_RD_TAIL)
   ) u_slot (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go(slot_go), .kind(slot_kind),
      .line_s(line_s), .oe(line_oe), .tick_clr(tick_clr), .done(slot_done),
      .bit_q(slot_bit));

   assign req_cmd = owm_cmd_e'(cmd);

   always_comb begin
      unique case (cur_cmd)
         OWM_CMD_RESET: slot_kind = SLOT_RST;
         OWM_CMD_READ:  slot_kind = SLOT_RD;
         default:       slot_kind = wsh[0] ? SLOT_WR1 : SLOT_WR0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cur_cmd <= OWM_CMD_NOP;
         bit_idx <= '0;
         wsh     <= '0;
         rsh     <= '0;
         rd_q    <= '0;
         pres_q  <= 1'b0;
         slot_go <= 1'b0;
      end else begin
         slot_go <= 1'b0;
         if (!busy_q) begin
            if (start && req_cmd != OWM_CMD_NOP) begin
               busy_q  <= 1'b1;
               cur_cmd <= req_cmd;
               wsh     <= wr_data;
               bit_idx <= '0;
               slot_go <= 1'b1;
            end
         end else if (slot_done) begin
            if (cur_cmd == OWM_CMD_RESET) begin
               pres_q <= !slot_bit;
               busy_q <= 1'b0;
            end else begin
               if (cur_cmd == OWM_CMD_WRITE) wsh <= wsh >> 1;
               if (cur_cmd == OWM_CMD_READ)  rsh <= {slot_bit, rsh[DATA_W-1:1]};
               if (bit_idx == IDX_W'(DATA_W - 1)) begin
                  busy_q <= 1'b0;
                  if (cur_cmd == OWM_CMD_READ) rd_q <= {slot_bit, rsh[DATA_W-1:1]};
               end else begin
                  bit_idx <= bit_idx + 1'b1;
                  slot_go <= 1'b1;
               end
            end
         end
      end
   end

   assign busy     = busy_q;
   assign rd_data  = rd_q;
   assign presence = pres_q;

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_oe); // R9
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && cmd != 2'd3) |=> busy); // R9
   AST_NOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && cmd == 2'd3) |=> !busy); // R11
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(rd_data) && $stable(presence))); // R10
   AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_cmd == OWM_CMD_WRITE) |=> $stable(rd_data)); // R10
endmodule

// File: tb/owm_master_tb_top.sv
module owm_master_tb_top;
   localparam int D = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmd = 2'd3;
   logic [7:0] wr_data = 8'h00;
   logic       start = 1'b0;
   logic       busy, presence, line_oe, line_in;
   logic [7:0] rd_data;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   // device model on the wire
   bit         dev_present = 1'b0, dev_rd_mode = 1'b0, dev_wr_mode = 1'b0;
   logic [7:0] dev_tx = 8'h00, dev_rx = 8'h00;
   int         dev_idx = 0, low_cnt = 0, last_low = 0, rel_cnt = 0, since_fall = 100000;
   int         width_bad = 0;
   bit         armed = 1'b0, cur_bit = 1'b1, prev_oe = 1'b0, dev_pull = 1'b0;

   always #2.5 clk = ~clk;

   assign line_in = !line_oe && !dev_pull;

   owm_master #(.CLKS_PER_US(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wr_data(wr_data), .start(start),
      .busy(busy), .rd_data(rd_data), .presence(presence),
      .line_oe(line_oe), .line_in(line_in));

   always @(negedge clk) begin
      if (line_oe && !prev_oe) begin
         low_cnt = 1; since_fall = 1; armed = 1'b0;
         if (dev_rd_mode) begin cur_bit = dev_tx[dev_idx]; dev_idx++; end
      end else if (line_oe) begin
         low_cnt++; since_fall++;
      end else if (prev_oe) begin
         last_low = low_cnt; rel_cnt = 1; since_fall++;
         armed = (low_cnt >= 400 * D);
         if (dev_wr_mode) begin
            dev_rx = {(low_cnt < 30 * D), dev_rx[7:1]};
            if (low_cnt != 6 * D && low_cnt != 60 * D) width_bad++;
         end
         if (dev_rd_mode && low_cnt != 6 * D) width_bad++;
      end else begin
         rel_cnt++; since_fall++;
      end
      prev_oe = line_oe;
      dev_pull = (dev_present && armed && rel_cnt >= 15 * D && rel_cnt <= 130 * D) ||
                 (dev_rd_mode && !cur_bit && since_fall < 30 * D);
   end

   function automatic int exp_busy(input logic [1:0] c);
      if (c == 2'd0) return 960 * D + 1;
      if (c == 2'd3) return 0;
      return 8 * (70 * D + 1);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // issue a command; optionally inject a second start mid-command
   task automatic run_cmd(input logic [1:0] c, input logic [7:0] d,
                          input bit inject, output int cyc);
      @(negedge clk);
      cmd = c; wr_data = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (busy && cyc < 100000) begin
         cyc++;
         if (inject && cyc == 100) begin cmd = 2'd2; wr_data = ~d; start = 1'b1; end
         else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] d, input string req);
      int cyc, wb0;
      wb0 = width_bad; dev_wr_mode = 1'b1; dev_rx = 8'h00;
      run_cmd(2'd1, d, 1'b0, cyc);
      dev_wr_mode = 1'b0;
      chk(dev_rx == d, req, dev_rx, d);
      chk(cyc == exp_busy(2'd1), req, cyc, exp_busy(2'd1));
      chk(width_bad == wb0, req, width_bad - wb0, 0);
   endtask

   task automatic do_read(input logic [7:0] d);
      int cyc, wb0;
      wb0 = width_bad; dev_rd_mode = 1'b1; dev_tx = d; dev_idx = 0; cur_bit = 1'b1;
      run_cmd(2'd2, 8'h00, 1'b0, cyc);
      dev_rd_mode = 1'b0; cur_bit = 1'b1;
      chk(rd_data == d, "R8", rd_data, d);
      chk(cyc == exp_busy(2'd2), "R7", cyc, exp_busy(2'd2));
      chk(width_bad == wb0, "R7", width_bad - wb0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int cyc;
      logic [7:0] v, held;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(!busy && !line_oe, "R1", {busy, line_oe}, 0);
      chk(rd_data == 8'h00 && !presence, "R1", {rd_data, presence}, 0);

      // R2 / R3 with a device answering
      dev_present = 1'b1;
      run_cmd(2'd0, 8'h00, 1'b0, cyc);
      chk(cyc == exp_busy(2'd0), "R2", cyc, exp_busy(2'd0));
      chk(last_low == 480 * D, "R2", last_low, 480 * D);
      chk(presence == 1'b1, "R3", presence, 1);
      // R3 with no device
      dev_present = 1'b0;
      run_cmd(2'd0, 8'h00, 1'b0, cyc);
      chk(presence == 1'b0, "R3", presence, 0);

      // R4 / R5 directed widths
      do_write(8'hFF, "R4");
      chk(last_low == 6 * D, "R4", last_low, 6 * D);
      do_write(8'h00, "R5");
      chk(last_low == 60 * D, "R5", last_low, 60 * D);
      // R6 random bytes, bit 0 first
      for (int i = 0; i < 6; i++) begin
         v = 8'($urandom);
         do_write(v, "R6");
      end
      do_write(8'h01, "R6");
      do_write(8'h80, "R6");

      // identification sequence
      dev_present = 1'b1;
      run_cmd(2'd0, 8'h00, 1'b0, cyc);
      chk(presence == 1'b1, "R3", presence, 1);
      do_write(8'h33, "R6");
      do_read(8'h01);
      for (int i = 0; i < 7; i++) do_read(8'($urandom));

      // R8 random and edge reads
      for (int i = 0; i < 5; i++) do_read(8'($urandom));
      do_read(8'h00);
      do_read(8'hFF);
      do_read(8'h6A);

      // R10: write and reset do not touch rd_data; read does not touch presence
      held = rd_data;
      do_write(8'h5C, "R6");
      chk(rd_data == held, "R10", rd_data, held);
      dev_present = 1'b0;
      run_cmd(2'd0, 8'h00, 1'b0, cyc);
      chk(rd_data == held && presence == 1'b0, "R10", {rd_data, presence}, {held, 1'b0});
      do_read(8'h3C);
      chk(presence == 1'b0, "R10", presence, 0);

      // R9: start during a write is ignored
      held = rd_data;
      dev_wr_mode = 1'b1; dev_rx = 8'h00;
      run_cmd(2'd1, 8'hA5, 1'b1, cyc);
      dev_wr_mode = 1'b0;
      chk(cyc == exp_busy(2'd1), "R9", cyc, exp_busy(2'd1));
      chk(dev_rx == 8'hA5 && rd_data == held, "R9", {dev_rx, rd_data}, {8'hA5, held});
      repeat (20) @(negedge clk);
      chk(!busy && !line_oe, "R9", {busy, line_oe}, 0);

      // R11: no-op command
      held = rd_data;
      run_cmd(2'd3, 8'hFF, 1'b0, cyc);
      chk(cyc == 0, "R11", cyc, 0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (busy || line_oe) begin
            chk(1'b0, "R11", {busy, line_oe}, 0);
            break;
         end
      end
      chk(rd_data == held && presence == 1'b0, "R11", {rd_data, presence}, {held, 1'b0});

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule